// File: doc/BRIEF.md
# Periodic Comparator Event Timer Channel

This block is a single comparator channel attached to a free-running 64-bit up-counter. Software reaches it through a 32-bit register port. Each 64-bit quantity (the counter and the comparator) appears as a low word at offset +0 and a high word at offset +4. When the counter steps onto the comparator value, the channel records an event. It can raise a level interrupt and, in periodic mode, move the comparator forward by a programmed period.

A set-value flag steers comparator writes. While the flag is armed, a comparator write loads the compare value itself. Once the flag is clear and periodic mode is on, comparator writes load the period instead. A 32-bit mode narrows matching to the lower words and leaves the counter counting over its full 64 bits.

Top module: `evtmr_channel`

## Requirements
- R1: After reset the counter, comparator, period, global enable and status are zero. The configuration low word reads 0x20 (only the capability bit), and `irq` is low.
- R2: Bit 0 of the global control word (offset 0x00) enables counting. While it is clear, writes to 0x08 (counter low) and 0x0C (counter high) load that half, and the counter holds. While it is set, the counter rises by one per clock, carrying from the low into the high word, and counter writes are ignored.
- R3: Configuration bit 5 (offset 0x10) always reads 1 and ignores writes. The configuration high word (0x14) reads zero.
- R4: A match occurs only on the clock where an increment makes the counter equal to the comparator (all 64 bits). A counter that is already past the comparator never matches again.
- R5: With configuration bit 8 set, matching and periodic advance use only the lower 32 bits, and the comparator high word is ignored. The counter still carries into its high word.
- R6: With configuration bit 3 (periodic) clear, a single comparator write (0x18 low, 0x1C high) sets that compare half. The comparator keeps its value after a match.
- R7: Writing configuration bit 6 as 1 arms a set-value load. A comparator low write then loads the compare low word and clears bit 6. A comparator high write loads the compare high word and leaves bit 6 set.
- R8: With bit 3 set and bit 6 clear, comparator writes load the period, and the compare value stays unchanged. On each match the comparator increases by the period.
- R9: Status bit 0 at offset 0x20 sets on a match while configuration bit 2 (interrupt enable) is set. Writing 1 to it clears it. Matches with bit 2 clear leave it at 0. `irq` is high exactly when status and bit 2 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Write strobes take effect at the clock edge they span. The counter's first increment comes on the edge after the one that sets the enable. A match sets status, advances the comparator and clears nothing else, all on the same edge that makes the counter equal to the comparator. All of these effects are therefore visible at the following falling edge. The bench drives and samples only at falling edges. After starting the counter at a known value, it counts exactly N falling edges and then checks both the last quiet edge (N-1) and the match edge (N). Reads are combinational, so a low/high pair taken at one falling edge sees one consistent counter value.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int HALF_W = 32;
  localparam int CNT_W  = 2 * HALF_W;
  localparam int ADDR_W = 6;

  // register word offsets; low word at +0, high word at +4
  localparam logic [ADDR_W-1:0] A_GCTL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h08;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CFG_LO = 6'h10;
  localparam logic [ADDR_W-1:0] A_CFG_HI = 6'h14;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 6'h18;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 6'h1C;
  localparam logic [ADDR_W-1:0] A_STS    = 6'h20;

  // configuration bit positions
  localparam int B_IE   = 2;
  localparam int B_PER  = 3;
  localparam int B_CAP  = 5;
  localparam int B_SETV = 6;
  localparam int B_M32  = 8;

  typedef struct packed {
    logic ie;
    logic periodic;
    logic setval;
    logic m32;
  } chan_cfg_t;

  // equality used for matching, narrowed in 32-bit mode
  function automatic logic hit_check(logic [CNT_W-1:0] cnt,
                                     logic [CNT_W-1:0] cmp, logic m32);
    if (m32) return cnt[HALF_W-1:0] == cmp[HALF_W-1:0];
    return cnt == cmp;
  endfunction

  // comparator advance by one period; upper word frozen in 32-bit mode
  function automatic logic [CNT_W-1:0] advance(logic [CNT_W-1:0] cmp,
                                               logic [CNT_W-1:0] per,
                                               logic m32);
    logic [CNT_W-1:0] s;
    s = cmp + per;
    if (m32) return {cmp[CNT_W-1:HALF_W], s[HALF_W-1:0]};
    return s;
  endfunction
endpackage

// File: rtl/evtmr_counter.sv
module evtmr_counter
  import evtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_nxt
);
  logic [1:0] ld;
  assign ld = {ld_hi, ld_lo};
  assign cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt_nxt;
    end else begin
      for (int h = 0; h < 2; h++)
        if (ld[h]) cnt[h*HALF_W +: HALF_W] <= wdata;
    end
  end

  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + CNT_W'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));
endmodule

// File: rtl/evtmr_comparator.sv
module evtmr_comparator
  import evtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  chan_cfg_t         cfg,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp,
  output logic              hit
);
  logic [1:0][HALF_W-1:0] cmp_q;
  logic [1:0][HALF_W-1:0] per_q;
  logic [CNT_W-1:0]       adv;
  logic [1:0]             wr;

  assign wr  = {wr_hi, wr_lo};
  assign cmp = cmp_q;
  assign hit = run && hit_check(cnt_nxt, cmp, cfg.m32);
  assign adv = advance(cmp, per_q, cfg.m32);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic ld_cmp, ld_per;
    assign ld_cmp = wr[h] && (cfg.setval || !cfg.periodic);
    assign ld_per = wr[h] && !cfg.setval && cfg.periodic;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[h] <= '0;
        per_q[h] <= '0;
      end else begin
        if (ld_cmp)
          cmp_q[h] <= wdata;
        else if (hit && cfg.periodic)
          cmp_q[h] <= adv[h*HALF_W +: HALF_W];
        if (ld_per) per_q[h] <= wdata;
      end
    end
  end

  // R8
  per_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg.periodic && !cfg.m32 && !wr_lo && !wr_hi)
      |=> cmp == $past(cmp) + $past(per_q));
  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg.periodic && !wr_lo && !wr_hi) |=> $stable(cmp));
  // R8
  per_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lo || wr_hi) && cfg.periodic && !cfg.setval && !hit) |=> $stable(cmp));
endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs
  import evtmr_pkg::*;
#(
  parameter bit WIDE_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              w_b0,
  input  logic              w_ie,
  input  logic              w_per,
  input  logic              w_setv,
  input  logic              w_m32,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic              hit,
  output logic              run,
  output chan_cfg_t         cfg,
  output logic              cnt_ld_lo,
  output logic              cnt_ld_hi,
  output logic              cmp_wr_lo,
  output logic              cmp_wr_hi,
  output logic              sts,
  output logic [HALF_W-1:0] rdata
);
  logic gctl_w, cfg_w, sts_w, setv_done;
  logic [HALF_W-1:0] cfg_rd;

  assign gctl_w    = bus_wr && bus_addr == A_GCTL;
  assign cfg_w     = bus_wr && bus_addr == A_CFG_LO;
  assign sts_w     = bus_wr && bus_addr == A_STS;
  assign cnt_ld_lo = bus_wr && bus_addr == A_CNT_LO;
  assign cnt_ld_hi = bus_wr && bus_addr == A_CNT_HI;
  assign cmp_wr_lo = bus_wr && bus_addr == A_CMP_LO;
  assign cmp_wr_hi = bus_wr && bus_addr == A_CMP_HI;
  assign setv_done = cmp_wr_lo && cfg.setval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cfg <= '0;
      sts <= 1'b0;
    end else begin
      if (gctl_w) run <= w_b0;
      if (cfg_w) begin
        cfg.ie       <= w_ie;
        cfg.periodic <= w_per;
        cfg.setval   <= w_setv;
        cfg.m32      <= w_m32;
      end else if (setv_done) begin
        cfg.setval <= 1'b0;
      end
      if (hit && cfg.ie)      sts <= 1'b1;
      else if (sts_w && w_b0) sts <= 1'b0;
    end
  end

  always_comb begin
    cfg_rd         = '0;
    cfg_rd[B_IE]   = cfg.ie;
    cfg_rd[B_PER]  = cfg.periodic;
    cfg_rd[B_CAP]  = WIDE_CAP;
    cfg_rd[B_SETV] = cfg.setval;
    cfg_rd[B_M32]  = cfg.m32;
  end

  always_comb begin
    unique case (bus_addr)
      A_GCTL:   rdata = {{(HALF_W-1){1'b0}}, run};
      A_CNT_LO: rdata = cnt[HALF_W-1:0];
      A_CNT_HI: rdata = cnt[CNT_W-1:HALF_W];
      A_CFG_LO: rdata = cfg_rd;
      A_CMP_LO: rdata = cmp[HALF_W-1:0];
      A_CMP_HI: rdata = cmp[CNT_W-1:HALF_W];
      A_STS:    rdata = {{(HALF_W-1){1'b0}}, sts};
      default:  rdata = '0;
    endcase
  end

  // R7
  setv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_lo && cfg.setval) |=> !cfg.setval);
  // R7
  setv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_hi && cfg.setval) |=> cfg.setval);
  // R9
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg.ie) |=> sts);
  // R9
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w && w_b0 && !hit) |=> !sts);
endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
  import evtmr_pkg::*;
#(
  parameter bit WIDE_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq
);
  logic             run, hit, sts;
  logic             cnt_ld_lo, cnt_ld_hi, cmp_wr_lo, cmp_wr_hi;
  logic [CNT_W-1:0] cnt, cnt_nxt, cmp;
  chan_cfg_t        cfg;

  evtmr_regs #(.WIDE_CAP(WIDE_CAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .w_b0(bus_wdata[0]), .w_ie(bus_wdata[B_IE]), .w_per(bus_wdata[B_PER]),
    .w_setv(bus_wdata[B_SETV]), .w_m32(bus_wdata[B_M32]),
    .cnt(cnt), .cmp(cmp), .hit(hit), .run(run), .cfg(cfg),
    .cnt_ld_lo(cnt_ld_lo), .cnt_ld_hi(cnt_ld_hi),
    .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi),
    .sts(sts), .rdata(bus_rdata)
  );

  evtmr_counter u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_lo(cnt_ld_lo), .ld_hi(cnt_ld_hi),
    .wdata(bus_wdata), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  evtmr_comparator u_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_nxt(cnt_nxt), .cfg(cfg),
    .wr_lo(cmp_wr_lo), .wr_hi(cmp_wr_hi), .wdata(bus_wdata),
    .cmp(cmp), .hit(hit)
  );

  assign irq = sts && cfg.ie;

  // R9
  irq_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts);
  // R4
  hit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg.periodic && !cmp_wr_lo && !cmp_wr_hi && !cnt_ld_lo && !cnt_ld_hi) |=> !hit);
endmodule

// File: tb/evtmr_channel_bench.sv
module evtmr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  evtmr_channel u_evtmr_channel (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd64(input logic [5:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 6'd4, hi);
    v = {hi, lo};
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] w;
    logic [63:0] v, v0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd64(6'h08, v); chk("R1 counter", v, 64'd0);
    rd64(6'h18, v); chk("R1 comparator", v, 64'd0);
    rd(6'h20, w);   chk("R1 status", {32'd0, w}, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    // R3 capability bit
    rd(6'h10, w); chk("R3 cfg reads cap", {32'd0, w}, 64'h20);
    wr(6'h10, 32'h0);
    rd(6'h10, w); chk("R3 cap read-only", {32'd0, w}, 64'h20);
    rd(6'h14, w); chk("R3 cfg high zero", {32'd0, w}, 64'd0);

    // R2 load while stopped, then count with carry
    wr(6'h08, 32'hFFFF_FFF0);
    wr(6'h0C, 32'h1);
    rd64(6'h08, v); chk("R2 load halves", v, 64'h1_FFFF_FFF0);
    wait_n(4);
    rd64(6'h08, v); chk("R2 hold stopped", v, 64'h1_FFFF_FFF0);
    wr(6'h00, 32'h1);
    rd64(6'h08, v); chk("R2 no step on enable edge", v, 64'h1_FFFF_FFF0);
    wait_n(20);
    rd64(6'h08, v); chk("R2 count with carry", v, 64'h2_0000_0004);
    v0 = v;
    wr(6'h08, 32'h0);
    rd64(6'h08, v); chk("R2 write ignored while counting", v, v0 + 64'd1);
    wr(6'h00, 32'h0);
    rd64(6'h08, v0);
    chk("R2 last step on disable edge", v0, v + 64'd1);
    wait_n(5);
    rd64(6'h08, v); chk("R2 stopped holds", v, v0);

    // R6 one-shot, R9 interrupt, R4 single match
    wr(6'h08, 32'd100); wr(6'h0C, 32'd0);
    wr(6'h1C, 32'd0);   wr(6'h18, 32'd110);
    wr(6'h10, 32'h4);
    wr(6'h00, 32'h1);
    wait_n(9);
    rd(6'h20, w); chk("R4 no match before equal", {32'd0, w}, 64'd0);
    chk("R9 irq low before match", {63'd0, irq}, 64'd0);
    wait_n(1);
    rd(6'h20, w); chk("R9 status on match", {32'd0, w}, 64'd1);
    chk("R9 irq high", {63'd0, irq}, 64'd1);
    rd64(6'h18, v); chk("R6 comparator kept", v, 64'd110);
    wr(6'h20, 32'h1);
    rd(6'h20, w); chk("R9 write-one clears", {32'd0, w}, 64'd0);
    wait_n(10);
    chk("R4 no rematch past compare", {63'd0, irq}, 64'd0);
    wr(6'h00, 32'h0);

    // R9 match with interrupt enable clear
    wr(6'h08, 32'd200); wr(6'h18, 32'd205);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h1);
    wait_n(8);
    wr(6'h10, 32'h4);
    rd(6'h20, w); chk("R9 masked match no status", {32'd0, w}, 64'd0);
    chk("R9 masked irq low", {63'd0, irq}, 64'd0);
    wr(6'h00, 32'h0);

    // R7 set-value handshake, R8 periodic reload
    wr(6'h08, 32'd0); wr(6'h0C, 32'd0);
    wr(6'h10, 32'h4C);
    wr(6'h1C, 32'd0);
    rd(6'h10, w); chk("R7 high write keeps flag", {63'd0, w[6]}, 64'd1);
    wr(6'h18, 32'd20);
    rd(6'h10, w); chk("R7 low write clears flag", {63'd0, w[6]}, 64'd0);
    wr(6'h18, 32'd7);
    wr(6'h1C, 32'd0);
    rd64(6'h18, v); chk("R8 period write leaves compare", v, 64'd20);
    wr(6'h00, 32'h1);
    wait_n(19);
    rd(6'h20, w); chk("R8 no match at 19", {32'd0, w}, 64'd0);
    wait_n(1);
    rd(6'h20, w); chk("R8 first periodic match", {32'd0, w}, 64'd1);
    rd64(6'h18, v); chk("R8 comparator advanced", v, 64'd27);
    wr(6'h20, 32'h1);
    wait_n(5);
    rd(6'h20, w); chk("R8 no match at 26", {32'd0, w}, 64'd0);
    wait_n(1);
    rd(6'h20, w); chk("R8 second periodic match", {32'd0, w}, 64'd1);
    rd64(6'h18, v); chk("R8 comparator advanced again", v, 64'd34);
    wr(6'h00, 32'h0);

    // R5 32-bit mode wraps low word, high compare ignored
    wr(6'h20, 32'h1);
    wr(6'h08, 32'hFFFF_FFF8); wr(6'h0C, 32'd5);
    wr(6'h10, 32'h104);
    wr(6'h1C, 32'd9); wr(6'h18, 32'd2);
    wr(6'h00, 32'h1);
    wait_n(9);
    rd(6'h20, w); chk("R5 no match before wrap", {32'd0, w}, 64'd0);
    wait_n(1);
    rd(6'h20, w); chk("R5 low-word match", {32'd0, w}, 64'd1);
    rd64(6'h08, v); chk("R5 counter stays 64-bit", v, 64'h6_0000_0002);
    wr(6'h00, 32'h0);

    // R4 full-width compare: same pattern without 32-bit mode
    wr(6'h20, 32'h1);
    wr(6'h08, 32'hFFFF_FFF8); wr(6'h0C, 32'd5);
    wr(6'h10, 32'h4);
    wr(6'h1C, 32'd9); wr(6'h18, 32'd2);
    wr(6'h00, 32'h1);
    wait_n(10);
    rd(6'h20, w); chk("R4 high half must match", {32'd0, w}, 64'd0);
    wr(6'h00, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule